// File: doc/BRIEF.md
# Outer CHR Bank Address Composer

This block builds the upper part of a pattern-memory address, bits A20 down to A10, for the picture fetch path of a banked cartridge controller. It combines an outer CHR base register, three bits of a mode register, a two-bit write-loaded CHR latch, the 8-bit 1 KiB bank number from an inner bank controller, and the picture processor's address bits A12..A10. The inner controller and any choice between CHR ROM and CHR RAM sit outside this block.

Software programs the outer registers through a small register window in the $5000-$5FFF range. It loads the latch by writing anywhere in $8000-$FFFF. The three mode bits pick one of five composition modes: INNER_256, INNER_128, DIRECT_L32, DIRECT_L16 and DIRECT_FLAT. Every change between modes is a write to the mode register, and each write can move from any mode to any other. The address output is purely combinational, so it follows the bank and picture address inputs within the same cycle.

The register window hits when CPU A15..A12 equal 5 and CPU address bit (4 + PAD_SEL) is 1. CPU A1..A0 then select the register. The parameter PAD_SEL, from 0 to 7, stands in for a board strap.

Top module: `chr_outer_bank`

## Requirements
- R1: After reset the mode register, base register and latch are all zero, so the output equals {3'b000, inner_bank}.
- R2: A write with cpu_addr[15:12] = 4'h5 and cpu_addr[4+PAD_SEL] = 1 is a register hit. On a hit, cpu_addr[1:0] = 0 stores cpu_data[6:4] as the mode bits, and cpu_addr[1:0] = 2 stores cpu_data as the base. Hits at index 1 or 3 and writes that miss the window change neither register.
- R3: Any write with cpu_addr[15] = 1 loads cpu_data[1:0] into the latch. No other write changes the latch.
- R4: INNER_256 (data bit 6 = 0, bit 4 = 0): output = {base[7:5], inner_bank[7:0]}.
- R5: INNER_128 (bit 6 = 0, bit 4 = 1): output = {base[7:4], inner_bank[6:0]}.
- R6: DIRECT_L32 (bit 6 = 1, bit 5 = 0, bit 4 = 0): output = {base[7:2], latch[1:0], ppu_a}.
- R7: DIRECT_L16 (bit 6 = 1, bit 5 = 0, bit 4 = 1): output = {base[7:1], latch[0], ppu_a}.
- R8: DIRECT_FLAT (bit 6 = 1, bit 5 = 1): output = {base[7:0], ppu_a}, and the latch has no effect.
- R9: The output is combinational in inner_bank and ppu_a. A change on those inputs appears in the same cycle.
- R10: When bit 6 = 0, mode bit 5 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| inner_bank | input | 8 | 1 KiB bank number from the inner controller |
| ppu_a | input | 3 | Picture address bits A12..A10 |
| chr_addr | output | 11 | Composed CHR address bits A20..A10 |

## Verification
The bench steps through all eight settings of the three mode bits. It combines each setting with base values of all zeros, all ones and alternating bit patterns, and with every latch value. This shows which base bits each mode lets through and where the latch lands. Inner bank and picture address patterns that differ in their top bits show whether the bank or the picture address supplies the low bits, and which bank bit the 128 KiB size drops. Writes just outside the register window, at the unused indices and below $8000 are each followed by a vector whose result depends on the state they must not disturb. Latch loads at both ends of $8000-$FFFF with full-byte data confirm that only data bits 1:0 are taken.

// File: rtl/chr_outer_pkg.sv
package chr_outer_pkg;

    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int BASE_W   = 8;
    localparam int INNER_W  = 8;
    localparam int LATCH_W  = 2;
    localparam int PPU_W    = 3;
    localparam int MODE_W   = 3;
    localparam int OUT_W    = BASE_W + PPU_W;
    localparam int IDX_W    = 2;

    // register indices inside the outer window
    localparam logic [IDX_W-1:0] IDX_MODE = 2'd0;
    localparam logic [IDX_W-1:0] IDX_BASE = 2'd2;

    // stored mode bits: [2] = direct source, [1] = latch off, [0] = small size
    typedef enum logic [2:0] {
        CM_INNER_256   = 3'd0,
        CM_INNER_128   = 3'd1,
        CM_DIRECT_L32  = 3'd2,
        CM_DIRECT_L16  = 3'd3,
        CM_DIRECT_FLAT = 3'd4
    } chr_mode_e;

endpackage

// File: rtl/chr_outer_regs.sv
module chr_outer_regs
    import chr_outer_pkg::*;
#(
    parameter int PAD_SEL = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_data,
    output logic [MODE_W-1:0]   mode_q,
    output logic [BASE_W-1:0]   base_q
);

    localparam int PAD_BIT = 4 + PAD_SEL;

    logic             win_hit;
    logic [IDX_W-1:0] idx;
    logic             wr_mode;
    logic             wr_base;
    logic             unused_addr;

    assign idx     = cpu_addr[IDX_W-1:0];
    assign win_hit = cpu_wr && (cpu_addr[15:12] == 4'h5) && cpu_addr[PAD_BIT];
    assign wr_mode = win_hit && (idx == IDX_MODE);
    assign wr_base = win_hit && (idx == IDX_BASE);

    assign unused_addr = ^{cpu_addr, cpu_data[7], cpu_data[3:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= cpu_data[6:4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_base) begin
            base_q <= cpu_data;
        end
    end

endmodule

// File: rtl/chr_latch.sv
module chr_latch
    import chr_outer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LATCH_W-1:0] din,
    output logic [LATCH_W-1:0] latch_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load) begin
            latch_q <= din;
        end
    end

endmodule

// File: rtl/chr_mode_decode.sv
module chr_mode_decode
    import chr_outer_pkg::*;
(
    input  logic [MODE_W-1:0] mode_bits,
    output chr_mode_e         mode
);

    always_comb begin
        mode = CM_INNER_256;
        unique casez (mode_bits)
            3'b0?0: mode = CM_INNER_256;
            3'b0?1: mode = CM_INNER_128;
            3'b100: mode = CM_DIRECT_L32;
            3'b101: mode = CM_DIRECT_L16;
            3'b11?: mode = CM_DIRECT_FLAT;
            default: mode = CM_INNER_256;
        endcase
    end

endmodule

// File: rtl/chr_addr_mux.sv
module chr_addr_mux
    import chr_outer_pkg::*;
(
    input  chr_mode_e           mode,
    input  logic [BASE_W-1:0]   base,
    input  logic [LATCH_W-1:0]  latch,
    input  logic [INNER_W-1:0]  inner_bank,
    input  logic [PPU_W-1:0]    ppu_a,
    output logic [OUT_W-1:0]    chr_addr
);

    always_comb begin
        chr_addr = '0;
        unique case (mode)
            CM_INNER_256:   chr_addr = {base[7:5], inner_bank[7:0]};
            CM_INNER_128:   chr_addr = {base[7:4], inner_bank[6:0]};
            CM_DIRECT_L32:  chr_addr = {base[7:2], latch[1:0], ppu_a};
            CM_DIRECT_L16:  chr_addr = {base[7:1], latch[0], ppu_a};
            CM_DIRECT_FLAT: chr_addr = {base, ppu_a};
            default:        chr_addr = '0;
        endcase
    end

endmodule

// File: rtl/chr_outer_bank.sv
module chr_outer_bank
    import chr_outer_pkg::*;
#(
    parameter int PAD_SEL = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_data,
    input  logic [7:0]          inner_bank,
    input  logic [2:0]          ppu_a,
    output logic [10:0]         chr_addr
);

    logic [MODE_W-1:0]  mode_q;
    logic [BASE_W-1:0]  base_q;
    logic [LATCH_W-1:0] latch_q;
    logic               latch_ld;
    chr_mode_e          mode;

    assign latch_ld = cpu_wr && cpu_addr[CPU_AW-1];

    chr_outer_regs #(.PAD_SEL(PAD_SEL)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .mode_q   (mode_q),
        .base_q   (base_q)
    );

    chr_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (latch_ld),
        .din     (cpu_data[LATCH_W-1:0]),
        .latch_q (latch_q)
    );

    chr_mode_decode u_dec (
        .mode_bits (mode_q),
        .mode      (mode)
    );

    chr_addr_mux u_mux (
        .mode       (mode),
        .base       (base_q),
        .latch      (latch_q),
        .inner_bank (inner_bank),
        .ppu_a      (ppu_a),
        .chr_addr   (chr_addr)
    );

endmodule

// File: rtl/chr_outer_bank_chk.sv
module chr_outer_bank_chk #(
    parameter int PAD_SEL = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_wr,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic [7:0]  inner_bank,
    input logic [2:0]  ppu_a,
    input logic [10:0] chr_addr,
    input logic [2:0]  mode_q,
    input logic [7:0]  base_q,
    input logic [1:0]  latch_q
);

    logic hit;
    assign hit = cpu_wr && (cpu_addr[15:12] == 4'h5) && cpu_addr[4 + PAD_SEL];

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (latch_q == $past(cpu_data[1:0])));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15]) |=> $stable(latch_q));

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cpu_addr[1:0] == 2'd2) |=> (base_q == $past(cpu_data)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && cpu_addr[1:0] == 2'd0) |=> $stable(mode_q));

    // R4
    inner_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[2] && !mode_q[0]) |-> (chr_addr[7:0] == inner_bank));

    // R8
    direct_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[2] |-> (chr_addr[2:0] == ppu_a));

endmodule

bind chr_outer_bank chr_outer_bank_chk #(.PAD_SEL(PAD_SEL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .inner_bank (inner_bank),
    .ppu_a      (ppu_a),
    .chr_addr   (chr_addr),
    .mode_q     (mode_q),
    .base_q     (base_q),
    .latch_q    (latch_q)
);

// File: tb/chr_outer_bank_tb.sv
`timescale 1ns/1ps
module chr_outer_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [7:0]  inner_bank = '0;
    logic [2:0]  ppu_a = '0;
    logic [10:0] chr_addr;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model of programmed state, from the requirements
    logic [7:0] m_mode = '0;
    logic [7:0] m_base = '0;
    logic [1:0] m_latch = '0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    chr_outer_bank #(.PAD_SEL(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .inner_bank(inner_bank), .ppu_a(ppu_a),
        .chr_addr(chr_addr)
    );

    function automatic logic [10:0] ref_addr(logic [7:0] md, logic [7:0] b,
                                            logic [1:0] l, logic [7:0] ib, logic [2:0] p);
        if (!md[6]) return md[4] ? {b[7:4], ib[6:0]} : {b[7:5], ib};
        if (md[5])  return {b, p};
        return md[4] ? {b[7:1], l[0], p} : {b[7:2], l, p};
    endfunction

    function automatic string mode_tag(logic [7:0] md);
        if (!md[6]) return md[4] ? "R5" : "R4";
        if (md[5])  return "R8";
        return md[4] ? "R7" : "R6";
    endfunction

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 16'h0000; cpu_data = 8'h00;
        if (a[15:12] == 4'h5 && a[4]) begin
            if (a[1:0] == 2'd0) m_mode = d;
            if (a[1:0] == 2'd2) m_base = d;
        end
        if (a[15]) m_latch = d[1:0];
    endtask

    task automatic apply(input logic [7:0] ib, input logic [2:0] p, input string tag);
        @(negedge clk);
        inner_bank = ib; ppu_a = p;
        exp_q.push_back(ref_addr(m_mode, m_base, m_latch, ib, p));
        tag_q.push_back(tag);
    endtask

    // monitor: compares shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (chr_addr !== e) begin
                    fails++;
                    $display("FAIL %s: chr_addr=%h expected=%h", t, chr_addr, e);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] bases[5];
        bases[0] = 8'h00; bases[1] = 8'hFF; bases[2] = 8'hA5;
        bases[3] = 8'h5A; bases[4] = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        apply(8'hA5, 3'b101, "R1");
        apply(8'h5A, 3'b010, "R1");
        // R9: output tracks inputs cycle by cycle
        apply(8'hFF, 3'b111, "R9");
        apply(8'h01, 3'b000, "R9");

        // R10: bit 5 ignored in inner mode
        cpu_write(16'h5012, 8'hE7);
        cpu_write(16'h5010, 8'h20);
        apply(8'hC3, 3'b110, "R10");
        cpu_write(16'h5010, 8'h30);
        apply(8'hC3, 3'b110, "R10");

        // R3: latch loads from top and bottom of upper range, full-byte data
        cpu_write(16'h5010, 8'h40);
        cpu_write(16'h5012, 8'h00);
        cpu_write(16'hFFFF, 8'hFE);
        apply(8'h00, 3'b011, "R3");
        cpu_write(16'h8000, 8'h01);
        apply(8'h00, 3'b011, "R3");
        cpu_write(16'h7FFF, 8'h03);
        apply(8'h00, 3'b011, "R3");

        // R2: decode window
        cpu_write(16'h5010, 8'h60);
        cpu_write(16'h5F16, 8'h81);
        apply(8'h00, 3'b100, "R2");
        cpu_write(16'h5002, 8'h7E);
        apply(8'h00, 3'b100, "R2");
        cpu_write(16'h5000, 8'h00);
        apply(8'h00, 3'b100, "R2");
        cpu_write(16'h5011, 8'h00);
        cpu_write(16'h5013, 8'hFF);
        apply(8'h00, 3'b100, "R2");
        cpu_write(16'h6012, 8'h55);
        cpu_write(16'h4010, 8'h00);
        apply(8'h00, 3'b100, "R2");

        // R4..R8 sweep of every mode-bit combination
        for (int m = 0; m < 8; m++) begin
            for (int bi = 0; bi < 5; bi++) begin
                for (int l = 0; l < 4; l++) begin
                    cpu_write(16'h5010, {1'b0, m[2:0], 4'b0000});
                    cpu_write(16'h5012, bases[bi]);
                    cpu_write(16'hA000, {6'b101010, l[1:0]});
                    apply(8'h80, 3'b001, mode_tag(m_mode));
                    apply(8'h7F, 3'b110, mode_tag(m_mode));
                    apply(8'h96, 3'b011, mode_tag(m_mode));
                end
            end
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule